// File: doc/BRIEF.md
# MAC Message Byte Sequencer

This block produces the fixed 88-byte message that a hash engine consumes when a message authentication code is computed. A one-cycle start request supplies a slot number and a mode byte. The block then reads the selected key slot, the temporary key register, the one-time-programmable region and the serial number. It interleaves those bytes with the command fields and presents the result, one byte per transfer, on a valid/ready stream.

Each storage array is reached through a plain synchronous read port. The block drives a read enable and an address, and the byte appears on the data input one clock later. The block issues each read one cycle ahead of the byte it presents. While the consumer holds ready low, no read is issued, so the byte on the stream stays unchanged.

Top module: `mac_msg_seq`

## Requirements
- R1: Stream bytes 0..31 are key-slot bytes at addresses 0..31 in ascending order. `key_slot_o` carries the slot number latched at start for the whole message.
- R2: Stream bytes 32..63 are temporary-key bytes at addresses 0..31 in ascending order.
- R3: Stream byte 64 is the opcode 0x08 and stream byte 65 is the latched mode byte.
- R4: Stream byte 66 is the latched slot number, zero-extended to 8 bits. Stream byte 67 is 0x00, the upper byte of the 16-bit parameter.
- R5: Stream bytes 68..78 are OTP bytes at addresses 0..10 in ascending order.
- R6: Stream bytes 79..87 are serial-number bytes at addresses 8, 4, 5, 6, 7, 0, 1, 2, 3, in that order.
- R7: A byte is transferred only in a cycle where `m_valid_o` and `m_ready_i` are both high. Exactly 88 bytes are transferred per message.
- R8: While `m_valid_o` is high and `m_ready_i` is low, the next cycle still has `m_valid_o` high with the same `m_data_o`. No byte is lost or repeated.
- R9: A start request in idle latches `slot_i` and `mode_i`. A start request while `busy_o` is high has no effect on the message being sent.
- R10: `done_o` is high for exactly one cycle, the cycle in which byte 87 is transferred. The following cycle `busy_o` is low and `m_valid_o` stays low until the next start.
- R11: Out of reset, `busy_o`, `m_valid_o`, `done_o` and all read enables are low.
- R12: At most one read enable is high in any cycle, and read enables are high only while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request |
| slot_i | input | 4 | Slot number for the message |
| mode_i | input | 8 | Mode byte for the message |
| key_slot_o | output | 4 | Latched slot number for the key store |
| key_rd_o | output | 1 | Key store read enable |
| key_addr_o | output | 5 | Key store byte address |
| key_data_i | input | 8 | Key store read data, one cycle after the read |
| tkey_rd_o | output | 1 | Temporary key read enable |
| tkey_addr_o | output | 5 | Temporary key byte address |
| tkey_data_i | input | 8 | Temporary key read data |
| otp_rd_o | output | 1 | OTP read enable |
| otp_addr_o | output | 4 | OTP byte address |
| otp_data_i | input | 8 | OTP read data |
| sn_rd_o | output | 1 | Serial-number read enable |
| sn_addr_o | output | 4 | Serial-number byte index |
| sn_data_i | input | 8 | Serial-number read data |
| m_valid_o | output | 1 | Stream byte valid |
| m_ready_i | input | 1 | Stream consumer ready |
| m_data_o | output | 8 | Stream byte |
| busy_o | output | 1 | Message in progress |
| done_o | output | 1 | Final byte transferred this cycle |

## Verification
Each of the 16 slot numbers runs a full message and is paired with its own mode byte, so a mix-up between the slot and mode fields, or between key slots, shows as a wrong byte. The bench runs every message under three consumer patterns: always ready, alternating ready, and pseudo-random ready. Always ready exposes ordering errors at full rate. Alternating ready exercises every issue/stall boundary. Pseudo-random ready exercises stall runs of varying length, which catches a read that is lost or repeated. The memory models return address- and slot-dependent values, so a permuted or off-by-one address is distinguishable. Some runs inject a start request with a different slot and mode in mid-message to show that it is ignored.

// File: rtl/mac_seq_pkg.sv
package mac_seq_pkg;
  typedef enum logic [2:0] {
    SRC_KEY   = 3'd0,
    SRC_TKEY  = 3'd1,
    SRC_OTP   = 3'd2,
    SRC_SN    = 3'd3,
    SRC_CONST = 3'd4
  } src_e;
endpackage

// File: rtl/mac_seq_decode.sv
module mac_seq_decode
  import mac_seq_pkg::*;
#(
  parameter int KEY_BYTES = 32,
  parameter int TK_BYTES  = 32,
  parameter int OTP_BYTES = 11,
  parameter int SN_BYTES  = 9,
  parameter int SLOT_W    = 4,
  parameter int CW        = 7,
  parameter int AW        = 5,
  parameter logic [7:0] OPCODE = 8'h08
) (
  input  logic [CW-1:0]     idx_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [7:0]        mode_i,
  output src_e              src_o,
  output logic [AW-1:0]     addr_o,
  output logic [7:0]        const_o
);
  localparam int TK_BASE  = KEY_BYTES;
  localparam int CMD_BASE = TK_BASE + TK_BYTES;
  localparam int OTP_BASE = CMD_BASE + 4;
  localparam int SN_BASE  = OTP_BASE + OTP_BYTES;
  localparam int SN_HALF  = (SN_BYTES - 1) / 2;

  always_comb begin
    int i;
    int k;
    i       = int'(idx_i);
    k       = 0;
    src_o   = SRC_CONST;
    addr_o  = '0;
    const_o = 8'h00;
    if (i < TK_BASE) begin
      src_o  = SRC_KEY;
      addr_o = AW'(i);
    end else if (i < CMD_BASE) begin
      src_o  = SRC_TKEY;
      addr_o = AW'(i - TK_BASE);
    end else if (i < OTP_BASE) begin
      src_o = SRC_CONST;
      case (i - CMD_BASE)
        0:       const_o = OPCODE;
        1:       const_o = mode_i;
        2:       const_o = 8'(slot_i);
        default: const_o = 8'h00;
      endcase
    end else if (i < SN_BASE) begin
      src_o  = SRC_OTP;
      addr_o = AW'(i - OTP_BASE);
    end else begin
      src_o = SRC_SN;
      k     = i - SN_BASE;
      if (k == 0)            addr_o = AW'(SN_BYTES - 1);
      else if (k <= SN_HALF) addr_o = AW'(k - 1 + SN_HALF);
      else                   addr_o = AW'(k - 1 - SN_HALF);
    end
  end
endmodule

// File: rtl/mac_seq_ctrl.sv
module mac_seq_ctrl #(
  parameter int MSG_LEN = 88,
  parameter int SLOT_W  = 4,
  parameter int CW      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [7:0]        mode_i,
  input  logic              ready_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic              done_o,
  output logic              issue_o,
  output logic [CW-1:0]     idx_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [7:0]        mode_o
);
  logic              busy_q, busy_d;
  logic              valid_q, valid_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [SLOT_W-1:0] slot_q;
  logic [7:0]        mode_q;
  logic              start_ok, accept, all_issued, issue, fin;

  always_comb begin
    start_ok   = !busy_q && start_i;
    accept     = valid_q && ready_i;
    all_issued = (cnt_q == CW'(MSG_LEN));
    issue      = busy_q && !all_issued && (!valid_q || ready_i);
    fin        = accept && all_issued;

    busy_d = busy_q;
    if (start_ok)  busy_d = 1'b1;
    else if (fin)  busy_d = 1'b0;

    cnt_d = cnt_q;
    if (start_ok)   cnt_d = '0;
    else if (issue) cnt_d = cnt_q + 1'b1;

    valid_d = valid_q;
    if (issue)       valid_d = 1'b1;
    else if (accept) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      valid_q <= valid_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      mode_q <= '0;
    end else if (start_ok) begin
      slot_q <= slot_i;
      mode_q <= mode_i;
    end
  end

  assign busy_o  = busy_q;
  assign valid_o = valid_q;
  assign done_o  = fin;
  assign issue_o = issue;
  assign idx_o   = cnt_q;
  assign slot_o  = slot_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/mac_seq_mux.sv
module mac_seq_mux
  import mac_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issue_i,
  input  src_e       src_i,
  input  logic [7:0] const_i,
  input  logic [7:0] key_data_i,
  input  logic [7:0] tkey_data_i,
  input  logic [7:0] otp_data_i,
  input  logic [7:0] sn_data_i,
  output logic [7:0] data_o
);
  src_e       src_q;
  logic [7:0] const_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= SRC_CONST;
      const_q <= '0;
    end else if (issue_i) begin
      src_q   <= src_i;
      const_q <= const_i;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_KEY:  data_o = key_data_i;
      SRC_TKEY: data_o = tkey_data_i;
      SRC_OTP:  data_o = otp_data_i;
      SRC_SN:   data_o = sn_data_i;
      default:  data_o = const_q;
    endcase
  end
endmodule

// File: rtl/mac_msg_seq.sv
module mac_msg_seq
  import mac_seq_pkg::*;
#(
  parameter int KEY_BYTES = 32,
  parameter int TK_BYTES  = 32,
  parameter int OTP_BYTES = 11,
  parameter int SN_BYTES  = 9,
  parameter int SLOT_W    = 4,
  parameter logic [7:0] OPCODE = 8'h08,
  localparam int MSG_LEN = KEY_BYTES + TK_BYTES + 4 + OTP_BYTES + SN_BYTES,
  localparam int CW      = $clog2(MSG_LEN + 1),
  localparam int KAW     = $clog2(KEY_BYTES),
  localparam int TAW     = $clog2(TK_BYTES),
  localparam int OAW     = $clog2(OTP_BYTES),
  localparam int SAW     = $clog2(SN_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [7:0]        mode_i,
  output logic [SLOT_W-1:0] key_slot_o,
  output logic              key_rd_o,
  output logic [KAW-1:0]    key_addr_o,
  input  logic [7:0]        key_data_i,
  output logic              tkey_rd_o,
  output logic [TAW-1:0]    tkey_addr_o,
  input  logic [7:0]        tkey_data_i,
  output logic              otp_rd_o,
  output logic [OAW-1:0]    otp_addr_o,
  input  logic [7:0]        otp_data_i,
  output logic              sn_rd_o,
  output logic [SAW-1:0]    sn_addr_o,
  input  logic [7:0]        sn_data_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [7:0]        m_data_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int AW01 = (KAW > TAW) ? KAW : TAW;
  localparam int AW23 = (OAW > SAW) ? OAW : SAW;
  localparam int AW   = (AW01 > AW23) ? AW01 : AW23;

  logic              issue;
  logic [CW-1:0]     idx;
  logic [SLOT_W-1:0] slot_q;
  logic [7:0]        mode_q;
  src_e              src;
  logic [AW-1:0]     addr;
  logic [7:0]        cbyte;

  mac_seq_ctrl #(.MSG_LEN(MSG_LEN), .SLOT_W(SLOT_W), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .slot_i(slot_i),
    .mode_i(mode_i), .ready_i(m_ready_i), .busy_o(busy_o),
    .valid_o(m_valid_o), .done_o(done_o), .issue_o(issue), .idx_o(idx),
    .slot_o(slot_q), .mode_o(mode_q)
  );

  mac_seq_decode #(
    .KEY_BYTES(KEY_BYTES), .TK_BYTES(TK_BYTES), .OTP_BYTES(OTP_BYTES),
    .SN_BYTES(SN_BYTES), .SLOT_W(SLOT_W), .CW(CW), .AW(AW), .OPCODE(OPCODE)
  ) u_dec (
    .idx_i(idx), .slot_i(slot_q), .mode_i(mode_q),
    .src_o(src), .addr_o(addr), .const_o(cbyte)
  );

  mac_seq_mux u_mux (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .src_i(src), .const_i(cbyte),
    .key_data_i(key_data_i), .tkey_data_i(tkey_data_i),
    .otp_data_i(otp_data_i), .sn_data_i(sn_data_i), .data_o(m_data_o)
  );

  assign key_slot_o  = slot_q;
  assign key_rd_o    = issue && (src == SRC_KEY);
  assign tkey_rd_o   = issue && (src == SRC_TKEY);
  assign otp_rd_o    = issue && (src == SRC_OTP);
  assign sn_rd_o     = issue && (src == SRC_SN);
  assign key_addr_o  = addr[KAW-1:0];
  assign tkey_addr_o = addr[TAW-1:0];
  assign otp_addr_o  = addr[OAW-1:0];
  assign sn_addr_o   = addr[SAW-1:0];
endmodule

// File: rtl/mac_msg_seq_chk.sv
module mac_msg_seq_chk #(
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [SLOT_W-1:0] key_slot_o,
  input logic              key_rd_o,
  input logic              tkey_rd_o,
  input logic              otp_rd_o,
  input logic              sn_rd_o,
  input logic              m_valid_o,
  input logic              m_ready_i,
  input logic [7:0]        m_data_o,
  input logic              busy_o,
  input logic              done_o
);
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o)));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!busy_o && !m_valid_o));

  assert_done_on_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (m_valid_o && m_ready_i));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_o) |=> $stable(key_slot_o));

  assert_one_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({key_rd_o, tkey_rd_o, otp_rd_o, sn_rd_o}));

  assert_read_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (key_rd_o || tkey_rd_o || otp_rd_o || sn_rd_o) |-> busy_o);

  assert_valid_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid_o |-> busy_o);
endmodule

bind mac_msg_seq mac_msg_seq_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_slot_o(key_slot_o),
  .key_rd_o(key_rd_o), .tkey_rd_o(tkey_rd_o), .otp_rd_o(otp_rd_o),
  .sn_rd_o(sn_rd_o), .m_valid_o(m_valid_o), .m_ready_i(m_ready_i),
  .m_data_o(m_data_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/mac_msg_seq_tb.sv
`timescale 1ns/1ps
module mac_msg_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [3:0] slot_i;
  logic [7:0] mode_i;
  logic [3:0] key_slot_o;
  logic       key_rd_o, tkey_rd_o, otp_rd_o, sn_rd_o;
  logic [4:0] key_addr_o, tkey_addr_o;
  logic [3:0] otp_addr_o, sn_addr_o;
  logic [7:0] key_data_i, tkey_data_i, otp_data_i, sn_data_i;
  logic       m_valid_o, m_ready_i, busy_o, done_o;
  logic [7:0] m_data_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] lf = 8'h5A;

  always #2 clk = ~clk;

  mac_msg_seq u_dut (.*);

  function automatic logic [7:0] key_val(input logic [3:0] s, input int a);
    return 8'((int'(s) * 37) + a * 3 + 1);
  endfunction
  function automatic logic [7:0] tk_val(input int a);
    return 8'(a) ^ 8'hA5;
  endfunction
  function automatic logic [7:0] otp_val(input int a);
    return 8'(8'h40 + a * 7);
  endfunction
  function automatic logic [7:0] sn_val(input int a);
    return 8'(8'hC0 + a * 5);
  endfunction

  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    lf  <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    if (key_rd_o)  key_data_i  <= key_val(key_slot_o, int'(key_addr_o));
    if (tkey_rd_o) tkey_data_i <= tk_val(int'(tkey_addr_o));
    if (otp_rd_o)  otp_data_i  <= otp_val(int'(otp_addr_o));
    if (sn_rd_o)   sn_data_i   <= sn_val(int'(sn_addr_o));
  end

  function automatic logic [7:0] exp_byte(input int i, input logic [3:0] s,
                                          input logic [7:0] m);
    int sn_order [9] = '{8, 4, 5, 6, 7, 0, 1, 2, 3};
    if (i < 32) return key_val(s, i);
    if (i < 64) return tk_val(i - 32);
    if (i == 64) return 8'h08;
    if (i == 65) return m;
    if (i == 66) return {4'h0, s};
    if (i == 67) return 8'h00;
    if (i < 79) return otp_val(i - 68);
    return sn_val(sn_order[i - 79]);
  endfunction

  function automatic string req_of(input int i);
    if (i < 32) return "R1";
    if (i < 64) return "R2";
    if (i < 66) return "R3";
    if (i < 68) return "R4";
    if (i < 79) return "R5";
    return "R6";
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_msg(input logic [3:0] s, input logic [7:0] m,
                         input int pat, input bit inject);
    int  n = 0;
    int  dones = 0;
    int  guard = 0;
    bit  stalled = 0;
    logic [7:0] held = 0;
    @(negedge clk);
    start_i = 1'b1; slot_i = s; mode_i = m;
    @(negedge clk);
    start_i = 1'b0; slot_i = ~s; mode_i = ~m;
    while (dones == 0 && guard < 1000) begin
      guard++;
      case (pat)
        0:       m_ready_i = 1'b1;
        1:       m_ready_i = cyc[0];
        default: m_ready_i = lf[0];
      endcase
      start_i = inject && (n == 20);
      #1;
      if (stalled) begin
        check(m_valid_o && m_data_o == held, "R8", int'(m_data_o), int'(held));
      end
      stalled = m_valid_o && !m_ready_i;
      held    = m_data_o;
      if (m_valid_o && m_ready_i) begin
        if (n < 88)
          check(m_data_o == exp_byte(n, s, m), req_of(n), int'(m_data_o),
                int'(exp_byte(n, s, m)));
        n++;
      end
      if (done_o) begin
        dones++;
        check(n == 88, "R10", n, 88);
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    check(n == 88, "R7", n, 88);
    check(dones == 1, "R10", dones, 1);
    m_ready_i = 1'b1;
    #1;
    check(!busy_o && !m_valid_o && !done_o, "R10", int'({busy_o, m_valid_o, done_o}), 0);
    @(negedge clk);
    #1;
    check(!m_valid_o, "R10", int'(m_valid_o), 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; slot_i = '0; mode_i = '0; m_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!busy_o && !m_valid_o && !done_o, "R11", int'({busy_o, m_valid_o, done_o}), 0);
    check(!(key_rd_o || tkey_rd_o || otp_rd_o || sn_rd_o), "R12",
          int'({key_rd_o, tkey_rd_o, otp_rd_o, sn_rd_o}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(!busy_o && !m_valid_o, "R11", int'({busy_o, m_valid_o}), 0);
    for (int p = 0; p < 3; p++) begin
      for (int s = 0; s < 16; s++) begin
        run_msg(4'(s), 8'(8'h71 + s * 13 + p), p, (s % 3) == 1);
      end
    end
    // R9: busy high after start with key_slot_o showing the latched slot
    @(negedge clk);
    start_i = 1'b1; slot_i = 4'd9; mode_i = 8'h33; m_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; slot_i = 4'd2;
    #1;
    check(busy_o && key_slot_o == 4'd9, "R9", int'(key_slot_o), 9);
    @(negedge clk);
    start_i = 1'b0;
    #1;
    check(key_slot_o == 4'd9, "R9", int'(key_slot_o), 9);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule